// File: doc/BRIEF.md
# Write-Through Store Buffer

This block sits between the store side of a write-through data cache and a slow main memory. Each store the processor issues is taken in one handshake. If the cache lookup reports a hit, the block sends a one-cycle update strobe to the cache data array. In every case, hit or miss, the store is queued for memory. A write miss never fetches or allocates a line, so the queued memory write is the only effect of a missed store.

The queue is a shallow first-in first-out buffer. Its depth is a parameter and defaults to four entries. The memory side sees the oldest entry whenever the queue holds anything. It retires that entry with a single acknowledge pulse, which it raises once its own multi-cycle write has finished. When stores arrive faster than memory retires them, the buffer fills and the store port stalls. No store is ever dropped. An empty flag lets later ordering logic, such as a fence, wait until every pending write has reached memory.

Top module: `wbuf_top`

## Requirements
- R1: After a synchronous reset, `buf_empty` is 1, `st_ready` is 1, `mem_req` is 0 and `cache_upd` is 0, whatever was queued before.
- R2: Entries reach the memory port (`mem_addr`, `mem_data`, `mem_be`) in exactly the order in which stores were accepted.
- R3: Once DEPTH (default 4) entries are queued and none retire, `st_ready` is 0. A store held valid during the stall is accepted later, unchanged, and not lost.
- R4: When a full buffer retires its head entry (`mem_req` and `mem_ack` both 1 at a clock edge), `st_ready` is 1 from the next cycle on.
- R5: A store accepted in the same cycle as a retirement leaves the occupancy unchanged, and both the remaining older entry and the new entry drain afterwards.
- R6: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_addr`, `mem_data` and `mem_be` keep their values into the next cycle.
- R7: A store accepted with `st_hit` = 1 produces `cache_upd` = 1 in the following cycle, with `cache_addr`, `cache_data` and `cache_be` equal to that store's fields.
- R8: A store accepted with `st_hit` = 0 leaves `cache_upd` at 0 in the following cycle and is still queued for memory (no allocation on a write miss).
- R9: `buf_empty` is 1 exactly when no entry is pending. It falls in the cycle after the first store is accepted and rises in the cycle after the last entry retires.
- R10: `mem_ack` while `mem_req` is 0 has no effect. The next store accepted is still presented and drained normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request from the processor |
| st_ready | output | 1 | Buffer can take a store this cycle |
| st_addr | input | AW | Store byte address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_hit | input | 1 | Cache tag lookup hit for this store |
| cache_upd | output | 1 | One-cycle write strobe to the cache data array |
| cache_addr | output | AW | Address for the cache update |
| cache_data | output | DW | Data for the cache update |
| cache_be | output | DW/8 | Byte enables for the cache update |
| mem_req | output | 1 | Head entry is valid for a memory write |
| mem_addr | output | AW | Head entry address |
| mem_data | output | DW | Head entry data |
| mem_be | output | DW/8 | Head entry byte enables |
| mem_ack | input | 1 | Memory finished writing the head entry |
| buf_empty | output | 1 | No pending memory writes |

## Verification
The hardest situation to reach is the saturated buffer, in which a stalled store waits behind a full queue while memory is still busy with a multi-cycle write. The stimulus fills the queue from a table of mixed hit and miss stores with the memory held off. It then holds a fifth store valid during several wait cycles, checking that the head stays stable. Only after that does it retire one entry, and it confirms that the waiting store enters unchanged and drains last. A separate sequence puts a store and a retirement in the same cycle, and checks by draining that exactly two entries remain.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int unsigned ADDR_W_DEF = 32;
  localparam int unsigned DATA_W_DEF = 32;
  localparam int unsigned DEPTH_DEF  = 4;

  // number of bits to hold a value 0..n
  function automatic int unsigned occ_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/wbuf_ptrs.sv
module wbuf_ptrs #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PW    = 2,
  parameter int unsigned CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] wr_idx,
  output logic [PW-1:0] rd_idx,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam bit            POW2     = (DEPTH & (DEPTH - 1)) == 0;

  logic [CW-1:0] occ;
  logic [PW-1:0] wr_nxt, rd_nxt;

  generate
    if (POW2) begin : g_wrap_nat
      assign wr_nxt = wr_idx + 1'b1;
      assign rd_nxt = rd_idx + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
      assign rd_nxt = (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      rd_idx <= '0;
      occ    <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (push) wr_idx <= wr_nxt;
      if (pop)  rd_idx <= rd_nxt;
      if (push && !pop) begin
        occ   <= occ + 1'b1;
        full  <= (occ + 1'b1) == FULL_CNT;
        empty <= 1'b0;
      end else if (pop && !push) begin
        occ   <= occ - 1'b1;
        full  <= 1'b0;
        empty <= occ == CW'(1);
      end
    end
  end

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == FULL_CNT && !pop) |=> (occ == FULL_CNT));

  // R5
  occ_same_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(occ));

  // R9
  drain_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(1) && pop && !push) |=> empty);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !(push && !pop && occ == FULL_CNT));
endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PW    = 2,
  parameter int unsigned EW    = 68
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] wr_idx,
  input  logic [EW-1:0] wr_ent,
  input  logic [PW-1:0] rd_idx,
  output logic [EW-1:0] rd_ent
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_ent;
  end

  assign rd_ent = mem[rd_idx];
endmodule

// File: rtl/wbuf_cache_port.sv
module wbuf_cache_port #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          hit,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [BW-1:0] be,
  output logic          upd,
  output logic [AW-1:0] upd_addr,
  output logic [DW-1:0] upd_data,
  output logic [BW-1:0] upd_be
);
  always_ff @(posedge clk) begin
    if (rst) begin
      upd      <= 1'b0;
      upd_addr <= '0;
      upd_data <= '0;
      upd_be   <= '0;
    end else begin
      upd <= acc && hit;
      if (acc) begin
        upd_addr <= addr;
        upd_data <= data;
        upd_be   <= be;
      end
    end
  end

  // R7
  hit_update_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && hit) |=> (upd && upd_addr == $past(addr) && upd_data == $past(data)
                      && upd_be == $past(be)));

  // R8
  miss_noalloc_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !hit) |=> !upd);
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top
  import wbuf_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W_DEF,
  parameter int unsigned DW    = DATA_W_DEF,
  parameter int unsigned DEPTH = DEPTH_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            st_valid,
  output logic            st_ready,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [DW/8-1:0] st_be,
  input  logic            st_hit,
  output logic            cache_upd,
  output logic [AW-1:0]   cache_addr,
  output logic [DW-1:0]   cache_data,
  output logic [DW/8-1:0] cache_be,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_data,
  output logic [DW/8-1:0] mem_be,
  input  logic            mem_ack,
  output logic            buf_empty
);
  localparam int unsigned BW = DW / 8;
  localparam int unsigned PW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int unsigned CW = occ_bits(DEPTH);
  localparam int unsigned EW = AW + DW + BW;

  logic          full, empty, push, pop;
  logic [PW-1:0] wr_idx, rd_idx;
  logic [EW-1:0] head;

  assign st_ready  = !full;
  assign push      = st_valid && !full;
  assign mem_req   = !empty;
  assign pop       = !empty && mem_ack;
  assign buf_empty = empty;
  assign {mem_be, mem_data, mem_addr} = head;

  wbuf_ptrs #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ptrs (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .full(full), .empty(empty)
  );

  wbuf_store #(.DEPTH(DEPTH), .PW(PW), .EW(EW)) u_store (
    .clk(clk), .we(push), .wr_idx(wr_idx), .wr_ent({st_be, st_data, st_addr}),
    .rd_idx(rd_idx), .rd_ent(head)
  );

  wbuf_cache_port #(.AW(AW), .DW(DW), .BW(BW)) u_cport (
    .clk(clk), .rst(rst), .acc(push), .hit(st_hit),
    .addr(st_addr), .data(st_data), .be(st_be),
    .upd(cache_upd), .upd_addr(cache_addr), .upd_data(cache_data), .upd_be(cache_be)
  );

  // R6
  head_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)
                               && $stable(mem_be)));

  // R4
  ready_back_chk: assert property (@(posedge clk) disable iff (rst)
    (!st_ready && mem_req && mem_ack) |=> st_ready);
endmodule

// File: tb/wbuf_top_bench.sv
module wbuf_top_bench;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int BW  = DW / 8;
  localparam int LAT = 3;
  localparam int NV  = 4;
  // {hit, be, data, addr}
  localparam logic [AW+DW+BW:0] VEC [NV] = '{
    {1'b1, 4'hF, 32'hDEAD_BEEF, 32'h0000_1000},
    {1'b0, 4'h3, 32'h1234_5678, 32'h0000_2004},
    {1'b1, 4'hC, 32'hCAFE_F00D, 32'h0000_3008},
    {1'b0, 4'h1, 32'h0BAD_F00D, 32'h0000_400C}
  };
  localparam logic [AW+DW+BW:0] XTRA = {1'b1, 4'hF, 32'hFACE_0001, 32'h0000_5010};

  logic clk = 0, rst = 1;
  logic st_valid = 0, st_hit = 0, mem_ack = 0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [BW-1:0] st_be = '0;
  logic st_ready, cache_upd, mem_req, buf_empty;
  logic [AW-1:0] cache_addr, mem_addr;
  logic [DW-1:0] cache_data, mem_data;
  logic [BW-1:0] cache_be, mem_be;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wbuf_top u_wbuf_top (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .st_hit(st_hit),
    .cache_upd(cache_upd), .cache_addr(cache_addr), .cache_data(cache_data),
    .cache_be(cache_be), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_be(mem_be), .mem_ack(mem_ack), .buf_empty(buf_empty)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [AW+DW+BW:0] v);
    {st_hit, st_be, st_data, st_addr} = v;
    st_valid = 1;
  endtask

  // one accepted store, returns at the negedge after acceptance
  task automatic do_store(input logic [AW+DW+BW:0] v);
    @(negedge clk);
    drive(v);
    while (!st_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    st_valid = 0;
  endtask

  // retire the head, checking it; called at a negedge, returns at a negedge
  task automatic drain_one(input string req, input logic [AW+DW+BW:0] v);
    check(req, "mem_req", 64'(mem_req), 64'd1);
    check(req, "mem_addr", 64'(mem_addr), 64'(v[AW-1:0]));
    check(req, "mem_data", 64'(mem_data), 64'(v[AW+DW-1:AW]));
    check(req, "mem_be", 64'(mem_be), 64'(v[AW+DW+BW-1:AW+DW]));
    mem_ack = 1;
    @(posedge clk);
    @(negedge clk);
    mem_ack = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1", "buf_empty", 64'(buf_empty), 64'd1);
    check("R1", "st_ready", 64'(st_ready), 64'd1);
    check("R1", "mem_req", 64'(mem_req), 64'd0);
    check("R1", "cache_upd", 64'(cache_upd), 64'd0);

    // table walk: fill the buffer with hits and misses, memory held off
    for (int i = 0; i < NV; i++) begin
      do_store(VEC[i]);
      if (VEC[i][AW+DW+BW]) begin
        check("R7", "cache_upd on hit", 64'(cache_upd), 64'd1);
        check("R7", "cache_addr", 64'(cache_addr), 64'(VEC[i][AW-1:0]));
        check("R7", "cache_data", 64'(cache_data), 64'(VEC[i][AW+DW-1:AW]));
        check("R7", "cache_be", 64'(cache_be), 64'(VEC[i][AW+DW+BW-1:AW+DW]));
      end else begin
        check("R8", "cache_upd on miss", 64'(cache_upd), 64'd0);
      end
      check("R9", "buf_empty after store", 64'(buf_empty), 64'd0);
    end

    // R3 full: stall a fifth store while memory is busy
    check("R3", "st_ready when full", 64'(st_ready), 64'd0);
    drive(XTRA);
    for (int c = 0; c < LAT; c++) begin
      @(posedge clk);
      @(negedge clk);
      check("R3", "st_ready stalled", 64'(st_ready), 64'd0);
      check("R6", "head addr held", 64'(mem_addr), 64'(VEC[0][AW-1:0]));
      check("R6", "mem_req held", 64'(mem_req), 64'd1);
    end
    // R2 head is oldest; retire it
    check("R2", "head data", 64'(mem_data), 64'(VEC[0][AW+DW-1:AW]));
    mem_ack = 1;
    @(posedge clk);
    @(negedge clk);
    mem_ack = 0;
    check("R4", "st_ready after retire", 64'(st_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    st_valid = 0;
    check("R3", "stalled store accepted", 64'(cache_upd), 64'd1);
    check("R3", "stalled store addr", 64'(cache_addr), 64'(XTRA[AW-1:0]));
    for (int i = 1; i < NV; i++) drain_one("R2", VEC[i]);
    drain_one("R3", XTRA);
    check("R9", "buf_empty after drain", 64'(buf_empty), 64'd1);
    check("R9", "mem_req after drain", 64'(mem_req), 64'd0);

    // R10 stray ack while empty
    mem_ack = 1;
    @(posedge clk);
    @(negedge clk);
    mem_ack = 0;
    check("R10", "buf_empty after stray ack", 64'(buf_empty), 64'd1);
    do_store(VEC[2]);
    drain_one("R10", VEC[2]);
    check("R10", "empty after single", 64'(buf_empty), 64'd1);

    // R5 push and pop together
    do_store(VEC[0]);
    do_store(VEC[1]);
    @(negedge clk);
    drive(VEC[3]);
    mem_ack = 1;
    @(posedge clk);
    @(negedge clk);
    st_valid = 0;
    mem_ack = 0;
    drain_one("R5", VEC[1]);
    drain_one("R5", VEC[3]);
    check("R5", "buf_empty after two", 64'(buf_empty), 64'd1);

    // R1 reset with entries pending
    do_store(VEC[0]);
    do_store(VEC[1]);
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1", "buf_empty after reset", 64'(buf_empty), 64'd1);
    check("R1", "mem_req after reset", 64'(mem_req), 64'd0);
    check("R1", "st_ready after reset", 64'(st_ready), 64'd1);
    check("R1", "cache_upd after reset", 64'(cache_upd), 64'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule